// File: doc/BRIEF.md
# Cascaded Match-Priority Node

This block is the per-device match-priority stage used when several content-addressable memory devices are stacked into one deeper table. Each device receives an active-low match input from the device above it and passes an active-low match flag output to the device below. The first device in the stack has its input tied inactive, and the flag output of the last device is the system-wide match. The word-by-word compare results arrive as a vector of per-word hit signals. They are already qualified by word validity.

A two-bit enable field selects whether the device takes part in the chain. When it is enabled, the device asserts its flag output if it has a hit of its own or if any device above it has one. Only the device with a hit and no hit above it answers a highest-priority-match operation. It reports the lowest-numbered matching word one cycle later. When the field is disabled, the device becomes transparent: its internal match term is held inactive, the flag output follows the input, and priority operations are dropped. Its raw match and multiple-match pins and its status bits still report the true compare state.

Top module: `match_chain_node`

## Requirements
- R1: After reset the enable field holds code 00 (participating) and `resp_v` is low.
- R2: `match_n` is low exactly when at least one bit of `hit_vec` is set, whatever the enable field holds.
- R3: `multi_n` is low exactly when two or more bits of `hit_vec` are set, whatever the enable field holds.
- R4: A clock edge with `cfg_we` high loads `cfg_mfe` into the enable field. Code 01 disables the device. Codes 00, 10 and 11 enable it.
- R5: While enabled, `flag_out_n` is low when `chain_in_n` is low or any bit of `hit_vec` is set, and high otherwise.
- R6: While disabled, `flag_out_n` equals `chain_in_n`, independent of `hit_vec`.
- R7: While enabled, a `prio_op` sampled with `chain_in_n` high and at least one hit makes `resp_v` high in the next cycle. In that cycle `resp_addr` gives the lowest set index of `hit_vec`.
- R8: A `prio_op` sampled while `chain_in_n` is low, or while no hit is present, gives `resp_v` low in the next cycle.
- R9: A `prio_op` sampled while the device is disabled gives `resp_v` low in the next cycle, even when hits are present.
- R10: `stat_hit` and `stat_multi` are active-high copies of the true single-hit and multiple-hit state, unaffected by the enable field.
- R11: In a cascade whose first input is tied high, at most one device answers a priority operation. That device is the highest enabled device that has a hit, and the last flag output is low exactly when some enabled device has a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vec | input | WORDS | Per-word compare hits, bit i for word i |
| cfg_we | input | 1 | Load strobe for the enable field |
| cfg_mfe | input | 2 | New enable field value (01 disables) |
| prio_op | input | 1 | Highest-priority-match operation request |
| chain_in_n | input | 1 | Active-low match from the device above |
| flag_out_n | output | 1 | Active-low match flag to the device below |
| match_n | output | 1 | Active-low true match pin |
| multi_n | output | 1 | Active-low true multiple-match pin |
| stat_hit | output | 1 | Status: any hit |
| stat_multi | output | 1 | Status: more than one hit |
| resp_v | output | 1 | This device answered the previous priority operation |
| resp_addr | output | AW | Word index of the answer |

## Verification
On every cycle, the assertions check four things: the chain pass-through while the device is enabled, the transparency while it is disabled, the multiple-hit pins, and the rule that a response is never produced for an operation that was blocked from above or that arrived while the device was disabled. Some behaviour spans several devices and only the bench's three-device cascade can show it: which device wins, the loading of all four field codes, and the correct index reported by the winner. That scenario also shows a disabled middle device being bypassed so that a lower one wins.

// File: rtl/match_chain_node.sv
module match_chain_node #(
  parameter int WORDS = 16,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] hit_vec,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mfe,
  input  logic             prio_op,
  input  logic             chain_in_n,
  output logic             flag_out_n,
  output logic             match_n,
  output logic             multi_n,
  output logic             stat_hit,
  output logic             stat_multi,
  output logic             resp_v,
  output logic [AW-1:0]    resp_addr
);

  localparam logic [1:0] MFE_OFF = 2'b01;

  logic [1:0]    mfe_q;
  logic          enabled;
  logic          any_hit;
  logic          many_hit;
  logic          own_match_n;
  logic [AW-1:0] first_idx;

  assign enabled     = (mfe_q != MFE_OFF);
  assign any_hit     = |hit_vec;
  assign many_hit    = ($countones(hit_vec) > 1);
  assign own_match_n = ~(enabled & any_hit);

  assign flag_out_n  = chain_in_n & own_match_n;
  assign match_n     = ~any_hit;
  assign multi_n     = ~many_hit;
  assign stat_hit    = any_hit;
  assign stat_multi  = many_hit;

  always_comb begin
    first_idx = '0;
    for (int i = WORDS - 1; i >= 0; i--)
      if (hit_vec[i]) first_idx = AW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mfe_q     <= 2'b00;
      resp_v    <= 1'b0;
      resp_addr <= '0;
    end else begin
      if (cfg_we) mfe_q <= cfg_mfe;
      resp_v <= prio_op & chain_in_n & ~own_match_n;
      if (prio_op & chain_in_n & ~own_match_n) resp_addr <= first_idx;
    end
  end

  a_r5_flag_carries_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mfe_q != MFE_OFF && hit_vec != '0) |-> !flag_out_n);

  a_r5_flag_carries_upstream: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in_n |-> !flag_out_n);

  a_r6_transparent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mfe_q == MFE_OFF) |-> (flag_out_n == chain_in_n));

  a_r3_multi_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & (hit_vec - 1'b1)) != '0) |-> (!multi_n && stat_multi && !match_n));

  a_r8_blocked_from_above: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_op && !chain_in_n) |=> !resp_v);

  a_r9_ignored_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_op && mfe_q == MFE_OFF && !cfg_we) |=> !resp_v);

  a_r7_resp_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_v) |-> $past(prio_op));

endmodule

// File: tb/match_chain_node_bench.sv
module match_chain_node_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 8;
  localparam int AW = 3;
  localparam int NDEV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prio_op = 1'b0;
  logic [WORDS-1:0] hits [NDEV];
  logic             we   [NDEV];
  logic [1:0]       cfg  [NDEV];

  logic [NDEV-1:0] flag_n, chain_n, m_n, mm_n, s_h, s_m, rv;
  logic [AW-1:0]   ra [NDEV];

  logic [1:0]    m_mfe [NDEV];
  logic          m_rv  [NDEV];
  logic [AW-1:0] m_ra  [NDEV];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign chain_n = {flag_n[NDEV-2:0], 1'b1};

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    match_chain_node #(.WORDS(WORDS)) u_match_chain_node (
      .clk(clk), .rst_n(rst_n), .hit_vec(hits[d]), .cfg_we(we[d]), .cfg_mfe(cfg[d]),
      .prio_op(prio_op), .chain_in_n(chain_n[d]), .flag_out_n(flag_n[d]),
      .match_n(m_n[d]), .multi_n(mm_n[d]), .stat_hit(s_h[d]), .stat_multi(s_m[d]),
      .resp_v(rv[d]), .resp_addr(ra[d]));
  end

  function automatic bit is_on(input int d);
    return m_mfe[d] != 2'b01;
  endfunction

  function automatic int popc(input logic [WORDS-1:0] v);
    int c = 0;
    for (int i = 0; i < WORDS; i++) c += v[i];
    return c;
  endfunction

  function automatic int lowest(input logic [WORDS-1:0] v);
    for (int i = 0; i < WORDS; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [NDEV-1:0] ref_chain_in();
    logic [NDEV-1:0] c;
    bit up = 1'b1;
    for (int d = 0; d < NDEV; d++) begin
      c[d] = up;
      if (is_on(d) && popc(hits[d]) > 0) up = 1'b0;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    logic [NDEV-1:0] ci;
    ci = ref_chain_in();
    for (int d = 0; d < NDEV; d++) begin
      if (!rst_n) begin
        m_mfe[d] <= 2'b00; m_rv[d] <= 1'b0; m_ra[d] <= '0;
      end else begin
        if (we[d]) m_mfe[d] <= cfg[d];
        if (prio_op && ci[d] && is_on(d) && popc(hits[d]) > 0) begin
          m_rv[d] <= 1'b1; m_ra[d] <= AW'(lowest(hits[d]));
        end else m_rv[d] <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int d, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dev%0d %s actual=%0d expected=%0d", req, d, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [NDEV-1:0] ci;
    int winners;
    if (!done && rst_n !== 1'bx) begin
      ci = ref_chain_in();
      winners = 0;
      for (int d = 0; d < NDEV; d++) begin
        chk("R2", "match_n", d, int'(m_n[d]), int'(popc(hits[d]) == 0));
        chk("R3", "multi_n", d, int'(mm_n[d]), int'(popc(hits[d]) < 2));
        chk("R10", "stat_hit", d, int'(s_h[d]), int'(popc(hits[d]) > 0));
        chk("R10", "stat_multi", d, int'(s_m[d]), int'(popc(hits[d]) > 1));
        if (is_on(d))
          chk("R5", "flag_out_n", d, int'(flag_n[d]), int'(ci[d] && popc(hits[d]) == 0));
        else
          chk("R6", "flag_out_n", d, int'(flag_n[d]), int'(ci[d]));
        chk(rst_n ? "R7" : "R1", "resp_v", d, int'(rv[d]), int'(m_rv[d]));
        if (m_rv[d]) chk("R7", "resp_addr", d, int'(ra[d]), int'(m_ra[d]));
        winners += int'(rv[d]);
      end
      chk("R11", "responders<=1", 0, int'(winners <= 1), 1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input int d, input logic [1:0] v);
    we[d] = 1'b1; cfg[d] = v;
    step(1);
    we[d] = 1'b0;
  endtask

  task automatic prio_pulse();
    prio_op = 1'b1;
    step(1);
    prio_op = 1'b0;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDEV; d++) begin hits[d] = '0; we[d] = 1'b0; cfg[d] = 2'b00; end
    step(3);
    rst_n = 1'b1;
    step(1);
    // R7 R8 R11: device 1 wins, device 2 blocked from above
    hits[1] = 8'b0001_0100; hits[2] = 8'b1000_0000;
    prio_pulse();
    // R4 R6 R9: disable device 1, device 2 now wins at word 7
    set_cfg(1, 2'b01);
    prio_pulse();
    // R4: code 10 enables; device 0 top priority at word 0
    set_cfg(1, 2'b10);
    hits[0] = 8'b1000_0001;
    prio_pulse();
    // R4: code 11 enables; devices 0 and 2 off, device 1 wins
    set_cfg(1, 2'b11);
    set_cfg(0, 2'b01);
    set_cfg(2, 2'b01);
    hits[2] = 8'b1111_1111;
    prio_pulse();
    // R9 R10: all off, raw pins still report hits
    set_cfg(1, 2'b01);
    prio_pulse();
    // R8: enabled but no hits
    set_cfg(0, 2'b00); set_cfg(1, 2'b00); set_cfg(2, 2'b00);
    for (int d = 0; d < NDEV; d++) hits[d] = '0;
    prio_pulse();
    // R7: single hit at the top word of the last device
    hits[2] = 8'b1000_0000;
    prio_pulse();
    // R1: reset restores enable code 00
    set_cfg(2, 2'b01);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    prio_pulse();
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule